// File: doc/BRIEF.md
# Configurable serial frame transmitter

The block takes one parallel character per accepted load and shifts it out, least significant bit first, on a single line that rests at 1. Mode inputs are sampled at load and fixed for that character. They choose between asynchronous framing and clocked synchronous framing. Asynchronous framing offers a start bit, 7 or 8 data bits, optional even or odd parity or a multiprocessor flag bit, and one or two stop bits. Clocked synchronous framing has 8 bare data bits and a serial clock output.

Bit timing comes from a one-cycle enable pulse supplied by an external rate generator. Each bit lasts `TICKS_PER_BIT` pulses, 16 by default. A load is taken only while busy is low. An end flag pulses for one cycle when the last bit period of a character finishes.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no character is in progress, `txd_o` is 1, `sclk_o` is 1, `busy_o` is 0 and `tx_end_o` is 0.
- R2: With `sync_mode_i`=0, the frame begins with one start bit of 0. Data bits follow, least significant bit first. Each bit is held for exactly 16 enable ticks.
- R3: With `char7_i`=1 in asynchronous mode, only data bits 0 to 6 are sent and bit 7 is dropped. With `char7_i`=0, all 8 bits are sent.
- R4: With `par_en_i`=1 and `mp_en_i`=0 in asynchronous mode, one parity bit follows the data bits. Its value is the XOR of the sent data bits, inverted when `par_odd_i`=1. So 0 selects even parity and 1 selects odd parity.
- R5: The asynchronous frame ends with stop bits of value 1. There is one stop bit when `stop2_i`=0 and two when `stop2_i`=1.
- R6: With `mp_en_i`=1 in asynchronous mode, exactly one bit equal to `mp_bit_i` follows the data bits. No parity bit is sent, whatever `par_en_i` and `par_odd_i` say.
- R7: With `sync_mode_i`=1, exactly 8 data bits are sent, least significant bit first, each lasting 16 ticks. There is no start, parity, multiprocessor or stop bit, and `char7_i`, `par_en_i`, `par_odd_i`, `stop2_i`, `mp_en_i` and `mp_bit_i` have no effect.
- R8: In synchronous mode, `sclk_o` is 0 during the first 8 ticks of each bit and 1 during the last 8. It falls when the bit starts, which is when the data changes. In asynchronous mode, and while idle, `sclk_o` stays 1.
- R9: `busy_o` rises in the cycle after a load is accepted and stays high until the last bit period ends. A `load_valid_i` pulse while `busy_o` is 1 is ignored and does not alter the character being sent.
- R10: `tx_end_o` is a one-cycle pulse. It is raised in the same cycle that `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Bit-rate enable pulse, one cycle wide |
| load_valid_i | input | 1 | Load request, accepted when busy_o is 0 |
| load_data_i | input | 8 | Character to send |
| sync_mode_i | input | 1 | 0 asynchronous, 1 clocked synchronous |
| char7_i | input | 1 | 0 eight data bits, 1 seven data bits |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 0 even parity, 1 odd parity |
| stop2_i | input | 1 | 0 one stop bit, 1 two stop bits |
| mp_en_i | input | 1 | Multiprocessor flag bit enable |
| mp_bit_i | input | 1 | Multiprocessor flag value (1 ID, 0 data) |
| busy_o | output | 1 | Character in progress |
| txd_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Serial clock for synchronous mode |
| tx_end_o | output | 1 | One-cycle end-of-character pulse |

## Verification
Several properties are checked on every cycle:
- `sclk_o` stays high outside synchronous characters.
- The end pulse is one cycle wide and coincides with the fall of busy.
- The shift state holds still between ticks, including while a load arrives during busy.
- The tick counter stays in range.

Bit values, frame lengths, parity polarity, the dropped bit 7, the suppressed parity in multiprocessor format and the ignored options in synchronous mode can only be shown by the bench. It sweeps every combination of the frame options in both modes and compares the line against frames it builds bit by bit.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  typedef struct packed {
    logic sync_mode;
    logic char7;
    logic par_en;
    logic par_odd;
    logic stop2;
    logic mp_en;
    logic mp_bit;
  } tx_cfg_t;
endpackage

// File: rtl/sftx_frame_build.sv
module sftx_frame_build
  import sftx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  tx_cfg_t            cfg_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o
);
  logic [DATA_W-1:0] sent_mask;
  logic              par_bit;
  int                pos;

  always_comb begin
    sent_mask = '1;
    if (cfg_i.char7) sent_mask[DATA_W-1] = 1'b0;
  end

  assign par_bit = ^(data_i & sent_mask) ^ cfg_i.par_odd;

  always_comb begin
    frame_o = '1;
    pos     = 0;
    if (cfg_i.sync_mode) begin
      frame_o[DATA_W-1:0] = data_i;
      pos = DATA_W;
    end else begin
      frame_o[0] = 1'b0;
      pos = 1;
      for (int i = 0; i < DATA_W; i++) begin
        if (sent_mask[i]) begin
          frame_o[pos] = data_i[i];
          pos = pos + 1;
        end
      end
      if (cfg_i.mp_en) begin
        frame_o[pos] = cfg_i.mp_bit;
        pos = pos + 1;
      end else if (cfg_i.par_en) begin
        frame_o[pos] = par_bit;
        pos = pos + 1;
      end
      // stop bits are the '1 fill
      pos = pos + (cfg_i.stop2 ? 2 : 1);
    end
    len_o = LEN_W'(pos);
  end
endmodule

// File: rtl/sftx_bit_timer.sv
module sftx_bit_timer #(
  parameter int TICKS_PER_BIT = 16,
  parameter int CNT_W         = $clog2(TICKS_PER_BIT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic sync_i,
  input  logic tick_i,
  output logic bit_done_o,
  output logic sclk_o
);
  localparam int HALF = TICKS_PER_BIT / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign bit_done_o = run_i && tick_i && (cnt_q == LAST);
  // low half first so the falling edge lines up with the data change
  assign sclk_o = !(run_i && sync_i && (int'(cnt_q) < HALF));

  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i && !start_i) |=> $stable(cnt_q));
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < TICKS_PER_BIT);
endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter #(
  parameter int FRAME_W = 12,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               sync_i,
  input  logic               bit_done_i,
  output logic               busy_o,
  output logic               sync_o,
  output logic               txd_o,
  output logic               end_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [LEN_W-1:0]   left_q;
  logic               busy_q, end_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
      end_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (accept_i) begin
        frame_q <= frame_i;
        left_q  <= len_i;
        busy_q  <= 1'b1;
        sync_q  <= sync_i;
      end else if (bit_done_i) begin
        if (left_q == LEN_W'(1)) begin
          busy_q <= 1'b0;
          end_q  <= 1'b1;
          sync_q <= 1'b0;
        end else begin
          frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
          left_q  <= left_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign sync_o = sync_q;
  assign txd_o  = busy_q ? frame_q[0] : 1'b1;
  assign end_o  = end_q;

  p_hold_between_ticks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !bit_done_i) |=> ($stable(frame_q) && $stable(left_q)));
  p_left_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (left_q != '0 && int'(left_q) <= FRAME_W));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_valid_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              sync_mode_i,
  input  logic              char7_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  input  logic              mp_en_i,
  input  logic              mp_bit_i,
  output logic              busy_o,
  output logic              txd_o,
  output logic              sclk_o,
  output logic              tx_end_o
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  tx_cfg_t            cfg;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               accept, bit_done, busy, sync_act;

  assign cfg = '{sync_mode: sync_mode_i, char7: char7_i, par_en: par_en_i,
                 par_odd: par_odd_i, stop2: stop2_i, mp_en: mp_en_i,
                 mp_bit: mp_bit_i};
  assign accept = load_valid_i && !busy;

  sftx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_build (
    .cfg_i(cfg), .data_i(load_data_i), .frame_o(frame), .len_o(len));

  sftx_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .frame_i(frame),
    .len_i(len), .sync_i(sync_mode_i), .bit_done_i(bit_done),
    .busy_o(busy), .sync_o(sync_act), .txd_o(txd_o), .end_o(tx_end_o));

  sftx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .run_i(busy),
    .sync_i(sync_act), .tick_i(tick_i), .bit_done_o(bit_done), .sclk_o(sclk_o));

  assign busy_o = busy;

  p_sclk_async_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_act |-> sclk_o);
  p_idle_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (txd_o && sclk_o));
  p_end_one_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_o |=> !tx_end_o);
  p_end_with_busy_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_o |-> $fell(busy_o));
  p_busy_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_valid_i && !busy_o) |=> busy_o);
endmodule

// File: tb/serial_frame_tx_bench.sv
module serial_frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPB        = 16;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, valid = 1'b0;
  logic [7:0] data = '0;
  logic sync_m = 0, c7 = 0, pe = 0, podd = 0, st2 = 0, mpe = 0, mpb = 0;
  logic busy, txd, sclk, tx_end;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_frame_tx u_serial_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .load_valid_i(valid),
    .load_data_i(data), .sync_mode_i(sync_m), .char7_i(c7), .par_en_i(pe),
    .par_odd_i(podd), .stop2_i(st2), .mp_en_i(mpe), .mp_bit_i(mpb),
    .busy_o(busy), .txd_o(txd), .sclk_o(sclk), .tx_end_o(tx_end));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic send(input logic [6:0] opt, input logic [7:0] d, input bit inject);
    bit exp_bits[16];
    int len, p;
    logic par;
    string rq;
    {sync_m, c7, pe, podd, st2, mpe, mpb} = opt;
    len = 0;
    if (sync_m) begin
      for (int i = 0; i < 8; i++) exp_bits[i] = d[i];
      len = 8;
      rq = "R7";
    end else begin
      exp_bits[0] = 0; p = 1; par = podd;
      for (int i = 0; i < (c7 ? 7 : 8); i++) begin
        exp_bits[p] = d[i]; par ^= d[i]; p++;
      end
      if (mpe) begin exp_bits[p] = mpb; p++; end
      else if (pe) begin exp_bits[p] = par; p++; end
      exp_bits[p] = 1; p++;
      if (st2) begin exp_bits[p] = 1; p++; end
      len = p;
      rq = mpe ? "R6" : (pe ? "R4" : (c7 ? "R3" : "R2"));
    end
    @(negedge clk) begin data = d; valid = 1'b1; end
    @(negedge clk) valid = 1'b0;
    chk("R9", "busy after load", int'(busy), 1);
    for (int b = 0; b < len; b++) begin
      for (int t = 0; t < TPB; t++) begin
        if (t == 0 || t == 8) chk(rq, $sformatf("txd bit %0d", b), int'(txd), int'(exp_bits[b]));
        if (t == 4 || t == 12)
          chk("R8", $sformatf("sclk bit %0d tick %0d", b, t), int'(sclk),
              (sync_m && t < 8) ? 0 : 1);
        if (inject && b == 1 && t == 2) begin
          data = ~d; valid = 1'b1;
          @(negedge clk) begin valid = 1'b0; data = d; end
          chk("R9", "busy held", int'(busy), 1);
        end
        if (b == len - 1 && t == TPB - 1) chk("R5", "busy before end", int'(busy), 1);
        tick_once();
      end
    end
    chk("R10", "tx_end pulse", int'(tx_end), 1);
    chk("R9", "busy fell", int'(busy), 0);
    chk("R1", "idle txd", int'(txd), 1);
    chk("R1", "idle sclk", int'(sclk), 1);
    @(negedge clk);
    chk("R10", "tx_end one cycle", int'(tx_end), 0);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset txd", int'(txd), 1);
    chk("R1", "reset sclk", int'(sclk), 1);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset tx_end", int'(tx_end), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // ticks while idle must not disturb anything
    tick_once();
    chk("R1", "idle tick txd", int'(txd), 1);
    chk("R1", "idle tick busy", int'(busy), 0);
    for (int o = 0; o < 64; o++) begin
      send({1'b0, 6'(o)}, 8'(8'hA5 ^ (o * 37)), (o % 5) == 0);
      send({1'b0, 6'(o)}, 8'(8'h3C + o * 11), 1'b0);
    end
    for (int o = 0; o < 64; o++)
      send({1'b1, 6'(o)}, 8'(8'h96 ^ (o * 53)), (o % 7) == 0);
    send(7'b0100000, 8'hFF, 1'b0);
    send(7'b1000000, 8'h00, 1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule